// File: doc/BRIEF.md
# Packed-Pixel Bitmap Memory Window

This block gives a processor a byte-addressed view of a packed pixel store. Each processor address names one pixel. The pixel is a 2-bit or 4-bit field inside a byte of a synchronous single-port RAM. A single format input selects the pixel depth. The processor sees every pixel as a whole byte: reads return the field alone, and writes change only the field.

A read request issues one RAM read. One cycle later the field comes back zero-extended, marked by a one-cycle valid pulse. A write request becomes a read-modify-write in two RAM cycles:
- the target byte is read in the request cycle;
- the merged byte is written in the next cycle, with busy high.

The controller is a three-state machine with these states:
- `ST_IDLE`: waiting for a request.
- `ST_RD_DATA`: the cycle in which read data is presented.
- `ST_WR_MERGE`: the cycle in which the merged byte is written.

It has these transitions:
- `ST_IDLE` or `ST_RD_DATA` goes to `ST_WR_MERGE` on an accepted write (TR_START_WR).
- `ST_IDLE` or `ST_RD_DATA` goes to `ST_RD_DATA` on an accepted read (TR_START_RD).
- `ST_IDLE` or `ST_RD_DATA` goes to `ST_IDLE` when there is no request (TR_NONE).
- `ST_WR_MERGE` always goes to `ST_IDLE` (TR_MERGE_DONE).

Top module: `pixel_window`

## Requirements
- R1: After reset, `busy`, `cpu_rvalid`, `mem_en` and `mem_we` are all 0.
- R2: The pixel address is the processor address minus the window base 0x6000, taken modulo 2^16. An address below the base wraps, so 0x5FFE becomes pixel 0xFFFE.
- R3: With `fmt_2bpp`=1, the RAM byte index is pixel>>2 and the field is bits [2k+1:2k], where k = pixel[1:0]. The index drives the 16-bit `mem_addr`.
- R4: With `fmt_2bpp`=0, the RAM byte index is pixel>>1 and the field is bits [4k+3:4k], where k = pixel[0].
- R5: A read drives `mem_en`=1, `mem_we`=0 and the byte index in the request cycle. In the following cycle `cpu_rvalid` is 1 for one cycle, and `cpu_rdata` holds the field zero-extended to 8 bits.
- R6: A write reads the target byte in the request cycle. In the next cycle it writes to the same `mem_addr` with `mem_we`=1, and `busy` is 1 during that cycle only.
- R7: The written byte equals the stored byte with the selected field replaced by the low 2 (or 4) bits of `cpu_wdata`. All other bits are unchanged, and the upper bits of `cpu_wdata` have no effect.
- R8: A request made while `busy` is 1 is ignored: it produces no valid pulse, no busy cycle and no RAM change.
- R9: When `cpu_rd` and `cpu_wr` are both 1, the write is performed and the read is dropped, so no `cpu_rvalid` pulse follows.
- R10: A new request is accepted in the cycle that presents read data. The format and address are captured per request, so back-to-back reads with different formats each return their own field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor pixel address |
| cpu_rd | input | 1 | Read request strobe |
| cpu_wr | input | 1 | Write request strobe |
| cpu_wdata | input | 8 | Write data; only the low field bits are used |
| fmt_2bpp | input | 1 | 1 selects 2-bit pixels, 0 selects 4-bit pixels |
| cpu_rdata | output | 8 | Zero-extended pixel read data |
| cpu_rvalid | output | 1 | One-cycle read data valid |
| busy | output | 1 | High during the merged-write cycle |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 16 | RAM byte address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after a read |

## Verification
Two functions can fall in the same cycle: presenting read data for one request and accepting the next request. A write can also land in that cycle and compete with the busy merge that follows.

The bench provokes the overlap by raising a new strobe exactly in the `cpu_rvalid` cycle, with a different address and format each time. Each returned field is judged against a value computed from the bench's own RAM image. A strobe raised during `busy` must leave the valid and busy outputs quiet in the following cycle.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int unsigned ADDR_W  = 16;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned LANE_W  = 2;
    localparam int unsigned SHIFT_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_DATA  = 2'd1,
        ST_WR_MERGE = 2'd2
    } pw_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] idx;
        logic [LANE_W-1:0] lane;
        logic              fmt2;
        logic [DATA_W-1:0] wdata;
    } pw_req_t;
endpackage

// File: rtl/pw_addr_map.sv
module pw_addr_map
    import pw_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WINDOW_BASE = 16'h6000
) (
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              fmt2,
    output logic [ADDR_W-1:0] byte_idx,
    output logic [LANE_W-1:0] lane
);
    logic [ADDR_W-1:0] pix;

    always_comb begin
        pix = cpu_addr - WINDOW_BASE;
        if (fmt2) begin
            byte_idx = pix >> 2;
            lane     = pix[1:0];
        end else begin
            byte_idx = pix >> 1;
            lane     = {1'b0, pix[0]};
        end
    end
endmodule

// File: rtl/pw_field_unit.sv
module pw_field_unit
    import pw_pkg::*;
(
    input  logic [DATA_W-1:0] stored,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANE_W-1:0] lane,
    input  logic              fmt2,
    output logic [DATA_W-1:0] field_mask,
    output logic [DATA_W-1:0] extracted,
    output logic [DATA_W-1:0] merged
);
    logic [SHIFT_W-1:0] sh;
    logic [DATA_W-1:0]  low_mask;

    for (genvar b = 0; b < DATA_W; b++) begin : g_mask
        localparam logic [LANE_W-1:0] LANE2 = LANE_W'(b / 2);
        localparam logic [LANE_W-1:0] LANE4 = LANE_W'(b / 4);
        assign field_mask[b] = fmt2 ? (lane == LANE2) : (lane == LANE4);
    end

    always_comb begin
        sh        = fmt2 ? {lane, 1'b0} : {lane[0], 2'b00};
        low_mask  = fmt2 ? 8'h03 : 8'h0F;
        extracted = (stored >> sh) & low_mask;
        merged    = (stored & ~field_mask) | (((wdata & low_mask) << sh) & field_mask);
    end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
    import pw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              fmt2,
    input  logic [ADDR_W-1:0] idx_now,
    input  logic [LANE_W-1:0] lane_now,
    input  logic [DATA_W-1:0] merged,
    output pw_req_t           req_q,
    output logic              cpu_rvalid,
    output logic              busy,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);
    pw_state_e state_q, state_d;
    logic      accept, start_wr, start_rd;

    assign accept   = (state_q != ST_WR_MERGE);
    assign start_wr = accept && cpu_wr;
    assign start_rd = accept && cpu_rd && !cpu_wr;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RD_DATA: begin
                if (start_wr)      state_d = ST_WR_MERGE;
                else if (start_rd) state_d = ST_RD_DATA;
                else               state_d = ST_IDLE;
            end
            ST_WR_MERGE:           state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start_wr || start_rd) begin
                req_q.idx   <= idx_now;
                req_q.lane  <= lane_now;
                req_q.fmt2  <= fmt2;
                req_q.wdata <= cpu_wdata;
            end
        end
    end

    always_comb begin
        cpu_rvalid = 1'b0;
        busy       = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = idx_now;
        mem_wdata  = merged;
        unique case (state_q)
            ST_IDLE, ST_RD_DATA: begin
                cpu_rvalid = (state_q == ST_RD_DATA);
                mem_en     = start_wr || start_rd;
            end
            ST_WR_MERGE: begin
                busy     = 1'b1;
                mem_en   = 1'b1;
                mem_we   = 1'b1;
                mem_addr = req_q.idx;
            end
            default: ;
        endcase
    end

    assert_merge_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !busy) |=> (mem_we && mem_en && busy));
    assert_merge_same_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr == $past(mem_addr)));
    assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && !busy) |=> cpu_rvalid);
    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && !cpu_rvalid));
    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_wr && !busy) |=> !cpu_rvalid);
endmodule

// File: rtl/pixel_window.sv
module pixel_window
    import pw_pkg::*;
#(
    parameter logic [15:0] WINDOW_BASE = 16'h6000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  cpu_wdata,
    input  logic        fmt_2bpp,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_rvalid,
    output logic        busy,
    output logic        mem_en,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    logic [ADDR_W-1:0] idx_now;
    logic [LANE_W-1:0] lane_now;
    logic [DATA_W-1:0] field_mask, extracted, merged;
    pw_req_t           req_q;

    pw_addr_map #(.WINDOW_BASE(WINDOW_BASE)) u_map (
        .cpu_addr (cpu_addr),
        .fmt2     (fmt_2bpp),
        .byte_idx (idx_now),
        .lane     (lane_now)
    );

    pw_field_unit u_field (
        .stored     (mem_rdata),
        .wdata      (req_q.wdata),
        .lane       (req_q.lane),
        .fmt2       (req_q.fmt2),
        .field_mask (field_mask),
        .extracted  (extracted),
        .merged     (merged)
    );

    pw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .fmt2       (fmt_2bpp),
        .idx_now    (idx_now),
        .lane_now   (lane_now),
        .merged     (merged),
        .req_q      (req_q),
        .cpu_rvalid (cpu_rvalid),
        .busy       (busy),
        .mem_en     (mem_en),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

    assign cpu_rdata = cpu_rvalid ? extracted : '0;

    assert_zero_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> ((cpu_rdata >> (req_q.fmt2 ? 2 : 4)) == 8'h00));
    assert_keep_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (((mem_wdata ^ mem_rdata) & ~field_mask) == 8'h00));
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!busy && !cpu_rvalid));
endmodule

// File: tb/sim_pixel_window.sv
module sim_pixel_window;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0, fmt_2bpp = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata, mem_wdata;
    logic        cpu_rvalid, busy, mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  ram [0:1023];
    int          n_checks = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_window u0 (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .fmt_2bpp(fmt_2bpp),
        .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid), .busy(busy),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= ram[mem_addr[9:0]];
            if (mem_we) ram[mem_addr[9:0]] <= mem_wdata;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pix_of(input logic [15:0] a);
        return a - 16'h6000;
    endfunction
    function automatic logic [15:0] idx_of(input logic [15:0] a, input logic f2);
        return f2 ? (pix_of(a) >> 2) : (pix_of(a) >> 1);
    endfunction
    function automatic int sh_of(input logic [15:0] a, input logic f2);
        return f2 ? int'(pix_of(a) & 16'd3) * 2 : int'(pix_of(a) & 16'd1) * 4;
    endfunction
    function automatic logic [7:0] fld_of(input logic [15:0] a, input logic f2);
        logic [7:0] m;
        m = f2 ? 8'h03 : 8'h0F;
        return (ram[idx_of(a, f2) % 1024] >> sh_of(a, f2)) & m;
    endfunction

    task automatic do_read(input string req, input logic [15:0] a, input logic f2);
        logic [7:0] exp;
        @(negedge clk);
        cpu_addr = a; fmt_2bpp = f2; cpu_rd = 1'b1;
        #1;
        check({req, " read addr"}, mem_addr, idx_of(a, f2));
        check({req, " read en"}, {mem_en, mem_we}, 2'b10);
        exp = fld_of(a, f2);
        @(negedge clk);
        cpu_rd = 1'b0;
        check({req, " rvalid"}, cpu_rvalid, 1'b1);
        check({req, " rdata"}, cpu_rdata, exp);
    endtask

    task automatic do_write(input string req, input logic [15:0] a, input logic f2, input logic [7:0] wd);
        logic [7:0] old, m, exp;
        int s;
        logic [15:0] ix;
        ix = idx_of(a, f2); s = sh_of(a, f2);
        m = f2 ? 8'h03 : 8'h0F;
        old = ram[ix % 1024];
        exp = (old & ~(m << s)) | ((wd & m) << s);
        @(negedge clk);
        cpu_addr = a; fmt_2bpp = f2; cpu_wr = 1'b1; cpu_wdata = wd;
        #1;
        check({req, " rmw read"}, {mem_en, mem_we, busy}, 3'b100);
        @(negedge clk);
        cpu_wr = 1'b0;
        check({req, " merge busy"}, {busy, mem_we, mem_en}, 3'b111);
        check({req, " merge addr"}, mem_addr, ix);
        @(negedge clk);
        check({req, " busy drop"}, busy, 1'b0);
        check({req, " stored"}, ram[ix % 1024], exp);
    endtask

    task automatic t_reset;
        check("R1 busy", busy, 1'b0);
        check("R1 rvalid", cpu_rvalid, 1'b0);
        check("R1 mem", {mem_en, mem_we}, 2'b00);
    endtask

    task automatic t_reads;
        for (int k = 0; k < 4; k++) do_read("R3 R5 2bpp lane", 16'h6000 + 16'(12 + k), 1'b1);
        for (int k = 0; k < 2; k++) do_read("R4 R5 4bpp lane", 16'h6081 + 16'(k), 1'b0);
    endtask

    task automatic t_wrap;
        do_read("R2 wrap", 16'h5FFE, 1'b1);
    endtask

    task automatic t_writes;
        do_write("R6 R7 2bpp", 16'h6000 + 16'd21, 1'b1, 8'hFE);
        do_write("R6 R7 4bpp", 16'h6000 + 16'd7, 1'b0, 8'hA5);
        do_write("R7 4bpp low", 16'h6000 + 16'd6, 1'b0, 8'h30);
        do_read("R7 readback", 16'h6000 + 16'd7, 1'b0);
    endtask

    task automatic t_busy_ignore;
        logic [7:0] snap;
        snap = ram[2];
        @(negedge clk);
        cpu_addr = 16'h6000 + 16'd8; fmt_2bpp = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h01;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = 16'h6000 + 16'd10;
        check("R8 busy", busy, 1'b1);
        @(negedge clk);
        cpu_rd = 1'b0;
        check("R8 no rvalid", cpu_rvalid, 1'b0);
        check("R8 no busy", busy, 1'b0);
        check("R8 ram", ram[2], (snap & 8'hFC) | 8'h01);
    endtask

    task automatic t_both;
        @(negedge clk);
        cpu_addr = 16'h6000 + 16'd17; fmt_2bpp = 1'b1; cpu_rd = 1'b1; cpu_wr = 1'b1; cpu_wdata = 8'h02;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        check("R9 no rvalid", cpu_rvalid, 1'b0);
        check("R9 busy", busy, 1'b1);
        @(negedge clk);
        check("R9 stored", (ram[4] >> 2) & 8'h03, 8'h02);
    endtask

    task automatic t_back_to_back;
        logic [7:0] e1, e2;
        e1 = fld_of(16'h6000 + 16'd41, 1'b1);
        e2 = fld_of(16'h6000 + 16'd51, 1'b0);
        @(negedge clk);
        cpu_addr = 16'h6000 + 16'd41; fmt_2bpp = 1'b1; cpu_rd = 1'b1;
        @(negedge clk);
        check("R10 first valid", cpu_rvalid, 1'b1);
        check("R10 first data", cpu_rdata, e1);
        cpu_addr = 16'h6000 + 16'd51; fmt_2bpp = 1'b0;
        #1;
        check("R10 second addr", mem_addr, 16'd25);
        @(negedge clk);
        cpu_rd = 1'b0;
        check("R10 second valid", cpu_rvalid, 1'b1);
        check("R10 second data", cpu_rdata, e2);
        @(negedge clk);
        check("R10 pulse ends", cpu_rvalid, 1'b0);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 1024; i++) ram[i] = 8'(i * 37 + 5);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reads();
        t_wrap();
        t_writes();
        t_busy_ignore();
        t_both();
        t_back_to_back();
        finish_run();
    end
endmodule